// File: doc/BRIEF.md
# Write-Back Line Replay Controller

This block sits in front of a write-back second-level cache and keeps request ordering correct around dirty-line evictions. Upstream requests are loads, stores and atomics, each aimed at one line of a small line-state table. Each line is clean, dirty, or in write-back (its dirty data has been sent downstream and the acknowledgement has not yet returned). Loads and stores to a clean or dirty line are served locally. Atomics always run at system scope. They are never executed in the cache and are always sent to the memory side.

A request that cannot proceed is parked in a small stall buffer. This covers an atomic that finds its line dirty: the controller first issues a write-back and parks the atomic. It also covers any request that finds its line in write-back. When the acknowledgement for that line returns, the line becomes clean. The parked requests for that line are then replayed in arrival order, one per cycle. A replayed load returns data, a replayed atomic goes downstream, and the response to an atomic comes back through the response port. Nothing parked is ever left behind.

Top module: `wb_replay_ctrl`

## Requirements
- R1: During and after reset, every line is clean and holds data zero, and the stall buffer is empty. No response or downstream request is issued, and req_ready is high.
- R2: An accepted load (req_op 0) to a clean or dirty line produces, on the next cycle, rsp_valid=1 with rsp_atomic=0, the request's id and the line's current data.
- R3: An accepted store (req_op 1) to a line not in write-back replaces the line's data and marks it dirty. It produces no response and no downstream request.
- R4: An accepted atomic (req_op 2) to a clean line is forwarded on the next cycle: mem_valid=1, mem_wb=0, with the line, id and operand data.
- R5: An atomic that finds its line dirty causes a write-back on the next cycle (mem_valid=1, mem_wb=1, with the line's data). The line enters write-back and the atomic is parked. No atomic for that line goes downstream until the write-back is acknowledged.
- R6: Any request to a line in write-back is parked, even when the buffer already holds entries for other lines. It produces no response and no downstream request.
- R7: A write-back acknowledgement makes the line clean. From the next cycle, parked requests whose line is not in write-back are replayed oldest first, one per cycle. Entries for lines still in write-back stay parked.
- R8: A replayed load returns the line's data. A replayed store updates the line. A replayed atomic is forwarded downstream, or triggers a fresh write-back if an earlier replayed store made the line dirty again.
- R9: req_ready is low whenever the buffer holds BUF_DEPTH entries, whenever a parked entry is eligible for replay, or whenever atom_rsp_valid is high.
- R10: An atomic result from memory (atom_rsp_valid) appears on the next cycle with rsp_valid=1, rsp_atomic=1 and the same id and data. It takes the response port ahead of all other work.
- R11: An acknowledgement for a line that is not in write-back has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Upstream request accepted this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 atomic |
| req_line | input | LINE_W | Target line index |
| req_id | input | ID_W | Requester tag |
| req_data | input | DATA_W | Store data or atomic operand |
| mem_valid | output | 1 | Downstream request valid |
| mem_wb | output | 1 | 1 write-back, 0 forwarded atomic |
| mem_line | output | LINE_W | Downstream line index |
| mem_id | output | ID_W | Requester tag of a forwarded atomic |
| mem_data | output | DATA_W | Dirty data or atomic operand |
| wb_ack_valid | input | 1 | Write-back acknowledgement |
| wb_ack_line | input | LINE_W | Line being acknowledged |
| atom_rsp_valid | input | 1 | Atomic result from memory |
| atom_rsp_id | input | ID_W | Tag of the atomic result |
| atom_rsp_data | input | DATA_W | Atomic result data |
| rsp_valid | output | 1 | Upstream response valid |
| rsp_atomic | output | 1 | Response carries an atomic result |
| rsp_id | output | ID_W | Response tag |
| rsp_data | output | DATA_W | Response data |

## Verification
Directed sequences cover the interesting orderings on a single line. The first is a dirty atomic followed by a load and a store that park behind it, which shows whether replay keeps arrival order and whether the load sees the data from before the store. The second is an acknowledgement for a line not in write-back, which shows whether stray acknowledgements change anything. The third fills the buffer and injects a memory atomic result, which separates the three causes of a low req_ready. Random traffic over a few lines, with random acknowledgements and atomic results, is compared every cycle against a transaction model in the bench. This exposes lost, reordered or early replays that the directed cases might not reach.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_ATOMIC = 2'd2,
    OP_RSVD   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    LN_CLEAN = 2'd0,
    LN_DIRTY = 2'd1,
    LN_WBACK = 2'd2,
    LN_UNUSED = 2'd3
  } lstate_e;
endpackage

// File: rtl/wbr_line_table.sv
module wbr_line_table
  import wbr_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int LINE_W    = 3,
  parameter int DATA_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LINE_W-1:0]    rd_line,
  output lstate_e              rd_state,
  output logic [DATA_W-1:0]    rd_data,
  input  logic                 wr_en,
  input  logic [LINE_W-1:0]    wr_line,
  input  lstate_e              wr_state,
  input  logic                 wr_data_en,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 ack_valid,
  input  logic [LINE_W-1:0]    ack_line,
  output logic [NUM_LINES-1:0] wb_vec
);
  lstate_e           state_q [NUM_LINES];
  logic [DATA_W-1:0] data_q  [NUM_LINES];

  assign rd_state = state_q[rd_line];
  assign rd_data  = data_q[rd_line];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_wb
    assign wb_vec[g] = (state_q[g] == LN_WBACK);
  end

  // The request path and the acknowledgement never touch the same line in
  // one cycle: the request path writes only lines not in write-back, and
  // the acknowledgement acts only on lines in write-back.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        state_q[i] <= LN_CLEAN;
        data_q[i]  <= '0;
      end
    end else begin
      if (wr_en) begin
        state_q[wr_line] <= wr_state;
        if (wr_data_en) data_q[wr_line] <= wr_data;
      end
      if (ack_valid && (state_q[ack_line] == LN_WBACK))
        state_q[ack_line] <= LN_CLEAN;
    end
  end
endmodule

// File: rtl/wbr_stall_buf.sv
module wbr_stall_buf
  import wbr_pkg::*;
#(
  parameter int BUF_DEPTH = 4,
  parameter int LINE_W    = 3,
  parameter int ID_W      = 4,
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 2,
  parameter int CNT_W     = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            push,
  input  op_e                             push_op,
  input  logic [LINE_W-1:0]               push_line,
  input  logic [ID_W-1:0]                 push_id,
  input  logic [DATA_W-1:0]               push_data,
  input  logic                            pop,
  input  logic [IDX_W-1:0]                pop_idx,
  input  logic [IDX_W-1:0]                rd_idx,
  output op_e                             rd_op,
  output logic [LINE_W-1:0]               rd_line,
  output logic [ID_W-1:0]                 rd_id,
  output logic [DATA_W-1:0]               rd_data,
  output logic [BUF_DEPTH-1:0]            ent_valid,
  output logic [BUF_DEPTH-1:0][LINE_W-1:0] ent_line,
  output logic [CNT_W-1:0]                count,
  output logic                            full
);
  op_e               op_q   [BUF_DEPTH];
  logic [LINE_W-1:0] line_q [BUF_DEPTH];
  logic [ID_W-1:0]   id_q   [BUF_DEPTH];
  logic [DATA_W-1:0] data_q [BUF_DEPTH];
  logic [CNT_W-1:0]  cnt_q;

  assign count   = cnt_q;
  assign full    = (cnt_q == CNT_W'(BUF_DEPTH));
  assign rd_op   = op_q[rd_idx];
  assign rd_line = line_q[rd_idx];
  assign rd_id   = id_q[rd_idx];
  assign rd_data = data_q[rd_idx];

  for (genvar g = 0; g < BUF_DEPTH; g++) begin : g_ent
    assign ent_valid[g] = (CNT_W'(g) < cnt_q);
    assign ent_line[g]  = line_q[g];
  end

  // Arrival order is kept by position: index 0 is the oldest entry.
  // Removal closes the gap by shifting younger entries down one slot.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (pop) begin
      for (int i = 0; i < BUF_DEPTH - 1; i++) begin
        if (i >= int'(pop_idx)) begin
          op_q[i]   <= op_q[i+1];
          line_q[i] <= line_q[i+1];
          id_q[i]   <= id_q[i+1];
          data_q[i] <= data_q[i+1];
        end
      end
      cnt_q <= cnt_q - 1'b1;
    end else if (push && !full) begin
      op_q[cnt_q[IDX_W-1:0]]   <= push_op;
      line_q[cnt_q[IDX_W-1:0]] <= push_line;
      id_q[cnt_q[IDX_W-1:0]]   <= push_id;
      data_q[cnt_q[IDX_W-1:0]] <= push_data;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wbr_replay_pick.sv
module wbr_replay_pick #(
  parameter int BUF_DEPTH = 4,
  parameter int NUM_LINES = 8,
  parameter int LINE_W    = 3,
  parameter int IDX_W     = 2
) (
  input  logic [BUF_DEPTH-1:0]             ent_valid,
  input  logic [BUF_DEPTH-1:0][LINE_W-1:0] ent_line,
  input  logic [NUM_LINES-1:0]             wb_vec,
  output logic                             hit,
  output logic [IDX_W-1:0]                 idx
);
  logic [BUF_DEPTH-1:0] elig;

  for (genvar g = 0; g < BUF_DEPTH; g++) begin : g_elig
    assign elig[g] = ent_valid[g] && !wb_vec[ent_line[g]];
  end

  // Lowest eligible index is the oldest request whose line is usable.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = BUF_DEPTH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/wb_replay_ctrl.sv
module wb_replay_ctrl
  import wbr_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int BUF_DEPTH = 4,
  parameter int ID_W      = 4,
  parameter int DATA_W    = 16,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int IDX_W    = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [LINE_W-1:0] req_line,
  input  logic [ID_W-1:0]   req_id,
  input  logic [DATA_W-1:0] req_data,
  output logic              mem_valid,
  output logic              mem_wb,
  output logic [LINE_W-1:0] mem_line,
  output logic [ID_W-1:0]   mem_id,
  output logic [DATA_W-1:0] mem_data,
  input  logic              wb_ack_valid,
  input  logic [LINE_W-1:0] wb_ack_line,
  input  logic              atom_rsp_valid,
  input  logic [ID_W-1:0]   atom_rsp_id,
  input  logic [DATA_W-1:0] atom_rsp_data,
  output logic              rsp_valid,
  output logic              rsp_atomic,
  output logic [ID_W-1:0]   rsp_id,
  output logic [DATA_W-1:0] rsp_data
);
  // Stall buffer signals
  op_e                              buf_op;
  logic [LINE_W-1:0]                buf_line;
  logic [ID_W-1:0]                  buf_id;
  logic [DATA_W-1:0]                buf_data;
  logic [BUF_DEPTH-1:0]             ent_valid;
  logic [BUF_DEPTH-1:0][LINE_W-1:0] ent_line;
  logic [CNT_W-1:0]                 buf_count;
  logic                             buf_full;
  logic                             buf_push;
  logic                             buf_pop;

  // Replay selection
  logic                             pick_hit;
  logic [IDX_W-1:0]                 pick_idx;

  // Line table signals
  lstate_e                          p_state;
  logic [DATA_W-1:0]                line_data;
  logic [NUM_LINES-1:0]             wb_vec;
  logic                             tbl_wr;
  lstate_e                          tbl_state;
  logic                             tbl_data_en;

  // Request being processed this cycle
  logic                             sel_replay;
  logic                             take_req;
  logic                             proc_en;
  op_e                              p_op;
  logic [LINE_W-1:0]                p_line;
  logic [ID_W-1:0]                  p_id;
  logic [DATA_W-1:0]                p_data;

  // Decisions
  logic                             do_park;
  logic                             do_load_rsp;
  logic                             do_fwd_atomic;
  logic                             do_writeback;

  wbr_stall_buf #(
    .BUF_DEPTH(BUF_DEPTH), .LINE_W(LINE_W), .ID_W(ID_W),
    .DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_buf (
    .clk(clk), .rst(rst),
    .push(buf_push), .push_op(p_op), .push_line(p_line),
    .push_id(p_id), .push_data(p_data),
    .pop(buf_pop), .pop_idx(pick_idx), .rd_idx(pick_idx),
    .rd_op(buf_op), .rd_line(buf_line), .rd_id(buf_id), .rd_data(buf_data),
    .ent_valid(ent_valid), .ent_line(ent_line),
    .count(buf_count), .full(buf_full)
  );

  wbr_replay_pick #(
    .BUF_DEPTH(BUF_DEPTH), .NUM_LINES(NUM_LINES),
    .LINE_W(LINE_W), .IDX_W(IDX_W)
  ) u_pick (
    .ent_valid(ent_valid), .ent_line(ent_line), .wb_vec(wb_vec),
    .hit(pick_hit), .idx(pick_idx)
  );

  wbr_line_table #(
    .NUM_LINES(NUM_LINES), .LINE_W(LINE_W), .DATA_W(DATA_W)
  ) u_tbl (
    .clk(clk), .rst(rst),
    .rd_line(p_line), .rd_state(p_state), .rd_data(line_data),
    .wr_en(tbl_wr), .wr_line(p_line), .wr_state(tbl_state),
    .wr_data_en(tbl_data_en), .wr_data(p_data),
    .ack_valid(wb_ack_valid), .ack_line(wb_ack_line), .wb_vec(wb_vec)
  );

  // Arbitration: memory results first, then replay, then new requests.
  // A new request is held off while any parked entry is eligible so that
  // it cannot overtake an older request to the same line.
  assign sel_replay = !atom_rsp_valid && pick_hit;
  assign req_ready  = !atom_rsp_valid && !pick_hit && !buf_full;
  assign take_req   = req_valid && req_ready;
  assign proc_en    = sel_replay || take_req;

  assign p_op   = sel_replay ? buf_op   : op_e'(req_op);
  assign p_line = sel_replay ? buf_line : req_line;
  assign p_id   = sel_replay ? buf_id   : req_id;
  assign p_data = sel_replay ? buf_data : req_data;

  always_comb begin
    do_park       = 1'b0;
    do_load_rsp   = 1'b0;
    do_fwd_atomic = 1'b0;
    do_writeback  = 1'b0;
    tbl_wr        = 1'b0;
    tbl_state     = p_state;
    tbl_data_en   = 1'b0;
    buf_pop       = 1'b0;
    if (proc_en) begin
      if (p_state == LN_WBACK) begin
        do_park = 1'b1;
      end else begin
        unique case (p_op)
          OP_STORE: begin
            tbl_wr      = 1'b1;
            tbl_state   = LN_DIRTY;
            tbl_data_en = 1'b1;
            buf_pop     = sel_replay;
          end
          OP_ATOMIC: begin
            if (p_state == LN_DIRTY) begin
              do_writeback = 1'b1;
              tbl_wr       = 1'b1;
              tbl_state    = LN_WBACK;
              do_park      = 1'b1;
            end else begin
              do_fwd_atomic = 1'b1;
              buf_pop       = sel_replay;
            end
          end
          default: begin
            do_load_rsp = 1'b1;
            buf_pop     = sel_replay;
          end
        endcase
      end
    end
  end

  // A replayed entry that must wait again simply stays where it is.
  assign buf_push = do_park && !sel_replay;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_atomic <= 1'b0;
      rsp_id     <= '0;
      rsp_data   <= '0;
      mem_valid  <= 1'b0;
      mem_wb     <= 1'b0;
      mem_line   <= '0;
      mem_id     <= '0;
      mem_data   <= '0;
    end else begin
      rsp_valid  <= atom_rsp_valid || do_load_rsp;
      rsp_atomic <= atom_rsp_valid;
      if (atom_rsp_valid) begin
        rsp_id   <= atom_rsp_id;
        rsp_data <= atom_rsp_data;
      end else if (do_load_rsp) begin
        rsp_id   <= p_id;
        rsp_data <= line_data;
      end
      mem_valid <= do_writeback || do_fwd_atomic;
      mem_wb    <= do_writeback;
      if (do_writeback || do_fwd_atomic) begin
        mem_line <= p_line;
        mem_id   <= p_id;
        mem_data <= do_writeback ? line_data : p_data;
      end
    end
  end
endmodule

// File: rtl/wb_replay_ctrl_chk.sv
module wb_replay_ctrl_chk #(
  parameter int NUM_LINES = 8,
  parameter int BUF_DEPTH = 4,
  parameter int ID_W      = 4,
  parameter int DATA_W    = 16,
  parameter int LINE_W    = 3,
  parameter int CNT_W     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic              mem_valid,
  input logic              mem_wb,
  input logic [LINE_W-1:0] mem_line,
  input logic              wb_ack_valid,
  input logic [LINE_W-1:0] wb_ack_line,
  input logic              atom_rsp_valid,
  input logic [ID_W-1:0]   atom_rsp_id,
  input logic [DATA_W-1:0] atom_rsp_data,
  input logic              rsp_valid,
  input logic              rsp_atomic,
  input logic [ID_W-1:0]   rsp_id,
  input logic [DATA_W-1:0] rsp_data,
  input logic [CNT_W-1:0]  buf_count,
  input logic              pick_hit
);
  // Lines with a write-back seen on the port and not yet acknowledged.
  logic [NUM_LINES-1:0] wb_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_out <= '0;
    end else begin
      if (mem_valid && mem_wb) wb_out[mem_line] <= 1'b1;
      if (wb_ack_valid) wb_out[wb_ack_line] <= 1'b0;
    end
  end

  // R5
  atomic_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_wb) |-> !wb_out[mem_line]);

  // R5
  single_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_wb) |-> !wb_out[mem_line]);

  // R9
  full_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (buf_count == CNT_W'(BUF_DEPTH)) |-> !req_ready);

  // R9
  atom_rsp_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
    atom_rsp_valid |-> !req_ready);

  // R10
  atom_rsp_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    atom_rsp_valid |=> (rsp_valid && rsp_atomic &&
                        rsp_id == $past(atom_rsp_id) &&
                        rsp_data == $past(atom_rsp_data)));

  // R3
  store_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op == 2'd1) |=> !rsp_valid);

  // R7
  replay_progress_chk: assert property (@(posedge clk) disable iff (rst)
    (pick_hit && !atom_rsp_valid) |=>
      ((buf_count < $past(buf_count)) || (mem_valid && mem_wb)));
endmodule

bind wb_replay_ctrl wb_replay_ctrl_chk #(
  .NUM_LINES(NUM_LINES), .BUF_DEPTH(BUF_DEPTH), .ID_W(ID_W),
  .DATA_W(DATA_W), .LINE_W(LINE_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/wb_replay_ctrl_bench.sv
`timescale 1ns/1ps
module wb_replay_ctrl_bench;
  localparam int NL = 8;
  localparam int BD = 4;
  localparam int IW = 4;
  localparam int DW = 16;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic [LW-1:0] req_line = '0;
  logic [IW-1:0] req_id = '0;
  logic [DW-1:0] req_data = '0;
  logic          mem_valid, mem_wb;
  logic [LW-1:0] mem_line;
  logic [IW-1:0] mem_id;
  logic [DW-1:0] mem_data;
  logic          wb_ack_valid = 1'b0;
  logic [LW-1:0] wb_ack_line = '0;
  logic          atom_rsp_valid = 1'b0;
  logic [IW-1:0] atom_rsp_id = '0;
  logic [DW-1:0] atom_rsp_data = '0;
  logic          rsp_valid, rsp_atomic;
  logic [IW-1:0] rsp_id;
  logic [DW-1:0] rsp_data;

  always #5 clk = ~clk;

  wb_replay_ctrl #(.NUM_LINES(NL), .BUF_DEPTH(BD), .ID_W(IW), .DATA_W(DW)) u_wb_replay_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_line(req_line), .req_id(req_id), .req_data(req_data),
    .mem_valid(mem_valid), .mem_wb(mem_wb), .mem_line(mem_line),
    .mem_id(mem_id), .mem_data(mem_data),
    .wb_ack_valid(wb_ack_valid), .wb_ack_line(wb_ack_line),
    .atom_rsp_valid(atom_rsp_valid), .atom_rsp_id(atom_rsp_id),
    .atom_rsp_data(atom_rsp_data),
    .rsp_valid(rsp_valid), .rsp_atomic(rsp_atomic), .rsp_id(rsp_id),
    .rsp_data(rsp_data)
  );

  int checks = 0;
  int failures = 0;

  // Transaction model: 0 clean, 1 dirty, 2 write-back
  int          m_st  [NL];
  logic [DW-1:0] m_dat [NL];
  int          bcnt;
  int          b_op  [BD];
  int          b_ln  [BD];
  logic [IW-1:0] b_id [BD];
  logic [DW-1:0] b_dt [BD];

  logic          e_rv, e_ra, e_mv, e_mw;
  logic [IW-1:0] e_rid, e_mid;
  logic [DW-1:0] e_rd, e_md;
  logic [LW-1:0] e_ml;
  string         e_rtag, e_mtag;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_dat[i] = '0; end
    bcnt = 0;
    e_rv = 0; e_ra = 0; e_mv = 0; e_mw = 0;
    e_rid = '0; e_mid = '0; e_rd = '0; e_md = '0; e_ml = '0;
    e_rtag = "R1"; e_mtag = "R1";
  endfunction

  function automatic void b_push(int op, int ln, logic [IW-1:0] id, logic [DW-1:0] d);
    b_op[bcnt] = op; b_ln[bcnt] = ln; b_id[bcnt] = id; b_dt[bcnt] = d;
    bcnt++;
  endfunction

  function automatic void b_remove(int k);
    for (int i = k; i < bcnt - 1; i++) begin
      b_op[i] = b_op[i+1]; b_ln[i] = b_ln[i+1];
      b_id[i] = b_id[i+1]; b_dt[i] = b_dt[i+1];
    end
    bcnt--;
  endfunction

  // One cycle of expected behaviour for the inputs currently driven.
  task automatic model_step();
    bit hit; int pk; bit rdy; bit ack_ok; bit sel;
    int op; int ln; logic [IW-1:0] id; logic [DW-1:0] d;
    hit = 0; pk = 0;
    for (int k = bcnt - 1; k >= 0; k--) if (m_st[b_ln[k]] != 2) begin hit = 1; pk = k; end
    rdy = !atom_rsp_valid && !hit && (bcnt < BD);
    chk(req_ready == rdy, "R9", "req_ready", 32'(req_ready), 32'(rdy));
    ack_ok = wb_ack_valid && (m_st[wb_ack_line] == 2);
    e_rv = 0; e_ra = 0; e_mv = 0; e_mw = 0;
    if (atom_rsp_valid) begin
      e_rv = 1; e_ra = 1; e_rid = atom_rsp_id; e_rd = atom_rsp_data; e_rtag = "R10";
    end else if (hit || (req_valid && rdy)) begin
      sel = hit;
      if (sel) begin op = b_op[pk]; ln = b_ln[pk]; id = b_id[pk]; d = b_dt[pk]; end
      else begin op = int'(req_op); ln = int'(req_line); id = req_id; d = req_data; end
      if (m_st[ln] == 2) begin
        if (!sel) b_push(op, ln, id, d);
      end else if (op == 1) begin
        m_st[ln] = 1; m_dat[ln] = d;
        if (sel) b_remove(pk);
      end else if (op == 2) begin
        if (m_st[ln] == 1) begin
          e_mv = 1; e_mw = 1; e_ml = LW'(ln); e_mid = id; e_md = m_dat[ln]; e_mtag = "R5";
          m_st[ln] = 2;
          if (!sel) b_push(op, ln, id, d);
        end else begin
          e_mv = 1; e_mw = 0; e_ml = LW'(ln); e_mid = id; e_md = d;
          e_mtag = sel ? "R8" : "R4";
          if (sel) b_remove(pk);
        end
      end else begin
        e_rv = 1; e_ra = 0; e_rid = id; e_rd = m_dat[ln]; e_rtag = sel ? "R8" : "R2";
        if (sel) b_remove(pk);
      end
    end
    if (ack_ok) m_st[wb_ack_line] = 0;
  endtask

  task automatic compare_outputs();
    chk(rsp_valid == e_rv, e_rv ? e_rtag : "R6", "rsp_valid", 32'(rsp_valid), 32'(e_rv));
    if (e_rv) begin
      chk(rsp_atomic == e_ra, e_rtag, "rsp_atomic", 32'(rsp_atomic), 32'(e_ra));
      chk(rsp_id == e_rid, e_rtag, "rsp_id", 32'(rsp_id), 32'(e_rid));
      chk(rsp_data == e_rd, e_rtag, "rsp_data", 32'(rsp_data), 32'(e_rd));
    end
    chk(mem_valid == e_mv, e_mv ? e_mtag : "R6", "mem_valid", 32'(mem_valid), 32'(e_mv));
    if (e_mv) begin
      chk(mem_wb == e_mw, e_mtag, "mem_wb", 32'(mem_wb), 32'(e_mw));
      chk(mem_line == e_ml, e_mtag, "mem_line", 32'(mem_line), 32'(e_ml));
      chk(mem_data == e_md, e_mtag, "mem_data", 32'(mem_data), 32'(e_md));
      if (!e_mw) chk(mem_id == e_mid, e_mtag, "mem_id", 32'(mem_id), 32'(e_mid));
    end
  endtask

  // Drive at the falling edge, step the model, let one rising edge pass,
  // then compare at the next falling edge.
  task automatic cyc(input bit rv, input int op, input int ln, input int id, input int d,
                     input bit av, input int al, input bit xv, input int xid, input int xd);
    req_valid = rv; req_op = 2'(op); req_line = LW'(ln); req_id = IW'(id); req_data = DW'(d);
    wb_ack_valid = av; wb_ack_line = LW'(al);
    atom_rsp_valid = xv; atom_rsp_id = IW'(xid); atom_rsp_data = DW'(xd);
    #1;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_outputs();
  endtask

  task automatic idle();            cyc(0,0,0,0,0, 0,0, 0,0,0); endtask
  task automatic req(int op, int ln, int id, int d); cyc(1,op,ln,id,d, 0,0, 0,0,0); endtask
  task automatic ack(int ln);       cyc(0,0,0,0,0, 1,ln, 0,0,0); endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int wl;
    process_seed: begin
      void'($urandom(32'h5EED_1234));
    end
    model_reset();
    repeat (3) @(negedge clk);
    // R1: outputs idle and ready high while reset is held
    chk(rsp_valid == 0 && mem_valid == 0, "R1", "idle in reset", {rsp_valid, mem_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1, "R1", "ready after reset", 32'(req_ready), 1);
    // R1/R2: reset data is zero
    req(0, 3, 1, 0);
    chk(rsp_valid && rsp_data == 0, "R1", "reset line data", 32'(rsp_data), 0);

    // R3: store is silent, then R2 load returns it
    req(1, 2, 2, 16'h00A5);
    chk(!rsp_valid && !mem_valid, "R3", "store silent", {rsp_valid, mem_valid}, 0);
    req(0, 2, 3, 0);
    chk(rsp_valid && rsp_data == 16'h00A5 && rsp_id == 3, "R2", "load data", 32'(rsp_data), 32'h00A5);

    // R4: atomic to a clean line goes straight downstream
    req(2, 1, 4, 16'h0101);
    chk(mem_valid && !mem_wb && mem_data == 16'h0101, "R4", "clean atomic", 32'(mem_data), 32'h0101);

    // R5: atomic to dirty line 2 triggers write-back and parks
    req(2, 2, 7, 16'h1111);
    chk(mem_valid && mem_wb && mem_data == 16'h00A5, "R5", "write-back data", 32'(mem_data), 32'h00A5);
    // R6: later load and store to line 2 park
    req(0, 2, 8, 0);
    chk(!rsp_valid, "R6", "load parked", 32'(rsp_valid), 0);
    req(1, 2, 9, 16'h5A5A);
    chk(!rsp_valid && !mem_valid, "R6", "store parked", {rsp_valid, mem_valid}, 0);
    // R6: other lines still served while entries wait
    req(2, 5, 10, 16'h0505);
    chk(mem_valid && !mem_wb && mem_line == 5, "R6", "other line served", 32'(mem_line), 5);

    // R11: stray acknowledgement to dirty line 4 has no effect
    req(1, 4, 11, 16'h4444);
    ack(4);
    req(2, 4, 12, 16'h0044);
    chk(mem_valid && mem_wb && mem_data == 16'h4444, "R11", "stray ack ignored", 32'(mem_wb), 1);

    // R7: acknowledge line 2, replay oldest first
    ack(2);
    idle();
    chk(mem_valid && !mem_wb && mem_id == 7, "R7", "first replay is atomic", 32'(mem_id), 7);
    idle();
    chk(rsp_valid && rsp_id == 8 && rsp_data == 16'h00A5, "R7", "second replay is load", 32'(rsp_data), 32'h00A5);
    idle();
    chk(!rsp_valid && !mem_valid, "R8", "store replay silent", {rsp_valid, mem_valid}, 0);
    req(0, 2, 13, 0);
    chk(rsp_valid && rsp_data == 16'h5A5A, "R8", "replayed store data", 32'(rsp_data), 32'h5A5A);
    ack(4);
    idle();
    chk(mem_valid && !mem_wb && mem_id == 12, "R8", "replayed atomic line 4", 32'(mem_id), 12);

    // R9: fill the buffer
    req(1, 6, 1, 16'h6666);
    req(2, 6, 2, 16'h0006);
    req(0, 6, 3, 0);
    req(0, 6, 4, 0);
    req(0, 6, 5, 0);
    #1;
    chk(req_ready == 0, "R9", "full buffer", 32'(req_ready), 0);
    // R10: memory atomic result passes through
    cyc(0,0,0,0,0, 0,0, 1,5,16'hBEEF);
    chk(rsp_valid && rsp_atomic && rsp_id == 5 && rsp_data == 16'hBEEF, "R10", "atomic result", 32'(rsp_data), 32'hBEEF);
    ack(6);
    repeat (6) idle();

    // Random traffic compared against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      bit av; int al;
      av = ($urandom_range(0, 99) < 20);
      al = $urandom_range(0, 3);
      if (av && $urandom_range(0, 3) != 0)
        for (int i = 0; i < 4; i++) if (m_st[i] == 2) al = i;
      cyc($urandom_range(0, 99) < 70, $urandom_range(0, 2), $urandom_range(0, 3),
          $urandom_range(0, 15), $urandom_range(0, 65535),
          av, al,
          $urandom_range(0, 99) < 8, $urandom_range(0, 15), $urandom_range(0, 65535));
    end

    // Drain: acknowledge every line in write-back until nothing waits
    for (int n = 0; n < 200 && bcnt > 0; n++) begin
      wl = 0;
      for (int i = 0; i < NL; i++) if (m_st[i] == 2) wl = i;
      ack(wl);
    end
    repeat (4) idle();
    chk(bcnt == 0 && req_ready == 1, "R7", "all parked requests drained", 32'(req_ready), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule